// File: doc/BRIEF.md
# Coherence Request Issue Scheduler

This block sits at the front of a pipelined L1 coherence controller. Each cycle it picks at most one pending request to enter the pipeline. There are eight request sources. The local core supplies load miss, store miss, flush, replacement and data-invalidate requests. The network side supplies forwarded coherence requests, coherence responses and recycled responses.

For every source, an eligibility gate combines several inputs:
- the MSHR lookup result for that source's block,
- the stall flag from that source's protocol stall table,
- the set indexes of the requests now in pipeline stages 2 and 3,
- the request network's availability.

A fixed-priority picker then chooses one eligible source. It acknowledges that source in the same cycle. It also registers the winner's class, address and MSHR lookup data toward stage 2.

The MSHR, the stall tables and the network interface are outside the block, and their results arrive as inputs. MSHR fullness is never checked. The MSHR holds twice as many entries as there are threads, so a free entry always exists.

Source numbering, which is also the class code on `out_class`, runs from highest to lowest priority:

| Code | Source |
|------|--------|
| 0 | flush |
| 1 | data invalidate |
| 2 | replacement |
| 3 | store miss |
| 4 | coherence response |
| 5 | forwarded request |
| 6 | load miss |
| 7 | recycled response |

Top module: `coh_issue_sched`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0. After release, it stays 0 until the first clock edge at which some source is eligible.
- R2: Load (6), store (3), data invalidate (1) and forwarded (5) requests are eligible only if one of these holds:
  - `mshr_hit` is 0;
  - the hit entry's valid bit is 0;
  - the entry is valid, its tag equals the request tag, and that source's `stall` bit is 0.
- R3: A source with a set index equal to `s2_set` while `s2_busy` is 1, or equal to `s3_set` while `s3_busy` is 1, is not eligible.
- R4: Flush (0), response (4) and recycled response (7) ignore `mshr_hit`, the entry fields and `stall`.
- R5: A replacement (2) that hits a valid MSHR entry is eligible in either of two cases, with no tag compare:
  - its `stall` bit is 0;
  - `mshr_ent_wfe` (waiting-for-eviction) is 1, even when `stall` is 1.
- R6: Sources 0, 1, 2, 3 and 6 need `net_ready` = 1. Sources 4, 5 and 7 do not.
- R7: Among eligible sources the lowest code wins. The order is flush, data invalidate, replacement, store, response, forwarded, load, recycled.
- R8: `deq_ack` is one-hot on the winning source in the same cycle it is eligible, and 0 when nothing is eligible.
- R9: At the next clock edge, the outputs take the winner's values:
  - `out_valid` goes to 1;
  - `out_class` takes the winner's code;
  - `out_tag` and `out_set` take its address;
  - `out_mshr_hit`, `out_mshr_idx`, `out_ent_valid`, `out_ent_tag` and `out_ent_wfe` take its MSHR lookup data.

  `out_valid` goes to 0 at an edge where nothing is eligible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 8 | Pending request per source |
| req_tag | input | 8 x TAG_W | Request tag per source |
| req_set | input | 8 x SET_W | Request set index per source |
| mshr_hit | input | 8 | MSHR lookup hit per source |
| mshr_idx | input | 8 x IDX_W | MSHR entry index per source |
| mshr_ent_valid | input | 8 | Valid bit of the looked-up entry |
| mshr_ent_tag | input | 8 x TAG_W | Tag of the looked-up entry |
| mshr_ent_wfe | input | 8 | Waiting-for-eviction bit of the entry |
| stall | input | 8 | Stall-table output per source |
| s2_busy | input | 1 | Stage 2 holds a valid request |
| s2_set | input | SET_W | Set index in stage 2 |
| s3_busy | input | 1 | Stage 3 holds a valid request |
| s3_set | input | SET_W | Set index in stage 3 |
| net_ready | input | 1 | Request network available |
| deq_ack | output | 8 | One-hot dequeue acknowledge |
| out_valid | output | 1 | Registered request valid toward stage 2 |
| out_class | output | 3 | Registered class code of winner |
| out_tag | output | TAG_W | Registered tag |
| out_set | output | SET_W | Registered set index |
| out_mshr_hit | output | 1 | Registered MSHR hit |
| out_mshr_idx | output | IDX_W | Registered MSHR index |
| out_ent_valid | output | 1 | Registered entry valid bit |
| out_ent_tag | output | TAG_W | Registered entry tag |
| out_ent_wfe | output | 1 | Registered waiting-for-eviction bit |

## Verification
The bench uses several kinds of input pattern, each aimed at telling one fault apart from others.

- **Priority:** all eight sources are raised and then withdrawn one at a time, from the top. This shows any swapped or missing priority position.
- **MSHR cases:** single-source patterns walk the load request through each MSHR case (mismatched tag, stalled match, clean match, invalid entry, no hit). The replacement is driven stalled with the waiting-for-eviction bit clear and then set. Together these separate the tag-checked rule from the eviction bypass.
- **Inputs that must not matter:** flush and responses are driven with hostile MSHR and stall inputs, which shows they ignore them.
- **Set conflicts and network:** same-set conflicts are raised in stage 2 and in stage 3 in turn. Dropping `net_ready` with every source pending picks out exactly which classes depend on the network.
- **Registered payload:** a fully populated winner confirms that every output field comes from the selected source.

// File: rtl/cis_pkg.sv
package cis_pkg;

    localparam int NUM_SRC = 8;

    typedef enum logic [2:0] {
        CLS_FLUSH = 3'd0,
        CLS_DINV  = 3'd1,
        CLS_REPL  = 3'd2,
        CLS_STORE = 3'd3,
        CLS_RESP  = 3'd4,
        CLS_FWD   = 3'd5,
        CLS_LOAD  = 3'd6,
        CLS_RECYC = 3'd7
    } req_class_e;

    // Per-source rule masks, bit position = class code
    localparam logic [NUM_SRC-1:0] MSHR_USERS   = 8'b0110_1110;
    localparam logic [NUM_SRC-1:0] TAG_CHECKED  = 8'b0110_1010;
    localparam logic [NUM_SRC-1:0] NET_USERS    = 8'b0100_1111;
    localparam logic [NUM_SRC-1:0] EVICT_BYPASS = 8'b0000_0100;

endpackage

// File: rtl/cis_src_gate.sv
module cis_src_gate #(
    parameter int TAG_W     = 8,
    parameter int SET_W     = 4,
    parameter bit USE_MSHR  = 1'b1,
    parameter bit CHECK_TAG = 1'b1,
    parameter bit NEED_NET  = 1'b1,
    parameter bit EVICT_OK  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_vld,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [SET_W-1:0] req_set,
    input  logic             hit,
    input  logic             ent_valid,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic             ent_wfe,
    input  logic             stall_in,
    input  logic             s2_busy,
    input  logic [SET_W-1:0] s2_set,
    input  logic             s3_busy,
    input  logic [SET_W-1:0] s3_set,
    input  logic             net_ready,
    output logic             eligible
);

    logic tag_ok;
    logic stall_ok;
    logic mshr_ok;
    logic set_clash;
    logic net_ok;

    always_comb begin
        tag_ok    = CHECK_TAG ? (ent_tag == req_tag) : 1'b1;
        stall_ok  = !stall_in || (EVICT_OK && ent_wfe);
        mshr_ok   = !hit || !ent_valid || (tag_ok && stall_ok);
        set_clash = (s2_busy && (s2_set == req_set)) ||
                    (s3_busy && (s3_set == req_set));
        net_ok    = NEED_NET ? net_ready : 1'b1;
        eligible  = req_vld && !set_clash && net_ok &&
                    (USE_MSHR ? mshr_ok : 1'b1);
    end

    p_stage2_clash_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_busy && (s2_set == req_set)) |-> !eligible);

    p_stage3_clash_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s3_busy && (s3_set == req_set)) |-> !eligible);

    p_net_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (NEED_NET && !net_ready) |-> !eligible);

    p_idle_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |-> !eligible);

endmodule

// File: rtl/cis_fixed_pick.sv
module cis_fixed_pick #(
    parameter int N     = 8,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] win_idx,
    output logic          any
);

    always_comb begin
        grant   = '0;
        win_idx = '0;
        any     = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (req[k] && !any) begin
                grant[k] = 1'b1;
                win_idx  = IW'(k);
                any      = 1'b1;
            end
        end
    end

    for (genvar k = 1; k < N; k++) begin : g_prio_chk
        p_lower_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            grant[k] |-> (req[k-1:0] == '0));
    end

endmodule

// File: rtl/coh_issue_sched.sv
module coh_issue_sched
    import cis_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter int SET_W = 4,
    parameter int IDX_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            req_vld,
    input  logic [NUM_SRC-1:0][TAG_W-1:0] req_tag,
    input  logic [NUM_SRC-1:0][SET_W-1:0] req_set,
    input  logic [NUM_SRC-1:0]            mshr_hit,
    input  logic [NUM_SRC-1:0][IDX_W-1:0] mshr_idx,
    input  logic [NUM_SRC-1:0]            mshr_ent_valid,
    input  logic [NUM_SRC-1:0][TAG_W-1:0] mshr_ent_tag,
    input  logic [NUM_SRC-1:0]            mshr_ent_wfe,
    input  logic [NUM_SRC-1:0]            stall,
    input  logic                          s2_busy,
    input  logic [SET_W-1:0]              s2_set,
    input  logic                          s3_busy,
    input  logic [SET_W-1:0]              s3_set,
    input  logic                          net_ready,
    output logic [NUM_SRC-1:0]            deq_ack,
    output logic                          out_valid,
    output logic [2:0]                    out_class,
    output logic [TAG_W-1:0]              out_tag,
    output logic [SET_W-1:0]              out_set,
    output logic                          out_mshr_hit,
    output logic [IDX_W-1:0]              out_mshr_idx,
    output logic                          out_ent_valid,
    output logic [TAG_W-1:0]              out_ent_tag,
    output logic                          out_ent_wfe
);

    localparam int CW = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] grant;
    logic [CW-1:0]      win;
    logic               any_win;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_gate
        cis_src_gate #(
            .TAG_W     (TAG_W),
            .SET_W     (SET_W),
            .USE_MSHR  (MSHR_USERS[s]),
            .CHECK_TAG (TAG_CHECKED[s]),
            .NEED_NET  (NET_USERS[s]),
            .EVICT_OK  (EVICT_BYPASS[s])
        ) u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_vld   (req_vld[s]),
            .req_tag   (req_tag[s]),
            .req_set   (req_set[s]),
            .hit       (mshr_hit[s]),
            .ent_valid (mshr_ent_valid[s]),
            .ent_tag   (mshr_ent_tag[s]),
            .ent_wfe   (mshr_ent_wfe[s]),
            .stall_in  (stall[s]),
            .s2_busy   (s2_busy),
            .s2_set    (s2_set),
            .s3_busy   (s3_busy),
            .s3_set    (s3_set),
            .net_ready (net_ready),
            .eligible  (elig[s])
        );
    end

    cis_fixed_pick #(.N(NUM_SRC)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (elig),
        .grant   (grant),
        .win_idx (win),
        .any     (any_win)
    );

    assign deq_ack = grant;

    // Stage-2 launch register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_class     <= CLS_FLUSH;
            out_tag       <= '0;
            out_set       <= '0;
            out_mshr_hit  <= 1'b0;
            out_mshr_idx  <= '0;
            out_ent_valid <= 1'b0;
            out_ent_tag   <= '0;
            out_ent_wfe   <= 1'b0;
        end else begin
            out_valid <= any_win;
            if (any_win) begin
                out_class     <= win;
                out_tag       <= req_tag[win];
                out_set       <= req_set[win];
                out_mshr_hit  <= mshr_hit[win];
                out_mshr_idx  <= mshr_idx[win];
                out_ent_valid <= mshr_ent_valid[win];
                out_ent_tag   <= mshr_ent_tag[win];
                out_ent_wfe   <= mshr_ent_wfe[win];
            end
        end
    end

    p_ack_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(deq_ack));

    p_ack_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_ack & ~req_vld) == '0);

    p_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_ack != '0) |=> out_valid);

    p_bubble_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_ack == '0) |=> !out_valid);

    p_class_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_ack != '0) |=> (deq_ack != '0 || 1'b1) && ($past(deq_ack) == (NUM_SRC'(1) << out_class)));

endmodule

// File: tb/coh_issue_sched_tb.sv
module coh_issue_sched_tb;

    localparam int TAG_W = 8;
    localparam int SET_W = 4;
    localparam int IDX_W = 3;
    localparam int NS    = 8;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [NS-1:0]             req_vld;
    logic [NS-1:0][TAG_W-1:0]  req_tag;
    logic [NS-1:0][SET_W-1:0]  req_set;
    logic [NS-1:0]             mshr_hit;
    logic [NS-1:0][IDX_W-1:0]  mshr_idx;
    logic [NS-1:0]             mshr_ent_valid;
    logic [NS-1:0][TAG_W-1:0]  mshr_ent_tag;
    logic [NS-1:0]             mshr_ent_wfe;
    logic [NS-1:0]             stall;
    logic                      s2_busy, s3_busy, net_ready;
    logic [SET_W-1:0]          s2_set, s3_set;
    logic [NS-1:0]             deq_ack;
    logic                      out_valid;
    logic [2:0]                out_class;
    logic [TAG_W-1:0]          out_tag;
    logic [SET_W-1:0]          out_set;
    logic                      out_mshr_hit;
    logic [IDX_W-1:0]          out_mshr_idx;
    logic                      out_ent_valid;
    logic [TAG_W-1:0]          out_ent_tag;
    logic                      out_ent_wfe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    coh_issue_sched #(.TAG_W(TAG_W), .SET_W(SET_W), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_tag(req_tag),
        .req_set(req_set), .mshr_hit(mshr_hit), .mshr_idx(mshr_idx),
        .mshr_ent_valid(mshr_ent_valid), .mshr_ent_tag(mshr_ent_tag),
        .mshr_ent_wfe(mshr_ent_wfe), .stall(stall), .s2_busy(s2_busy),
        .s2_set(s2_set), .s3_busy(s3_busy), .s3_set(s3_set),
        .net_ready(net_ready), .deq_ack(deq_ack), .out_valid(out_valid),
        .out_class(out_class), .out_tag(out_tag), .out_set(out_set),
        .out_mshr_hit(out_mshr_hit), .out_mshr_idx(out_mshr_idx),
        .out_ent_valid(out_ent_valid), .out_ent_tag(out_ent_tag),
        .out_ent_wfe(out_ent_wfe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        req_vld = '0; mshr_hit = '0; mshr_ent_valid = '0; mshr_ent_wfe = '0;
        stall = '0; s2_busy = 1'b0; s3_busy = 1'b0; net_ready = 1'b1;
        s2_set = '0; s3_set = '0;
        for (int i = 0; i < NS; i++) begin
            req_tag[i] = TAG_W'(8'h10 + i);
            req_set[i] = SET_W'(i);
            mshr_idx[i] = IDX_W'(i);
            mshr_ent_tag[i] = TAG_W'(8'h10 + i);
        end
    endtask

    // Check ack now, then the registered launch after the next edge
    task automatic step(input logic [NS-1:0] exp_ack, input string req);
        int code;
        #1;
        chk(deq_ack == exp_ack, req, 32'(deq_ack), 32'(exp_ack));
        @(posedge clk); #1;
        chk(out_valid == (exp_ack != '0), req, 32'(out_valid), 32'(exp_ack != '0));
        if (exp_ack != '0) begin
            code = 0;
            for (int i = 0; i < NS; i++) if (exp_ack[i]) code = i;
            chk(out_class == 3'(code), req, 32'(out_class), 32'(code));
        end
    endtask

    task automatic t_reset();
        clear_all();
        req_vld = '1;
        #5;
        chk(out_valid == 1'b0, "R1 during reset", 32'(out_valid), 0);
        @(posedge clk); #1;
        chk(out_valid == 1'b0, "R1 reset held", 32'(out_valid), 0);
        req_vld = '0;
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(out_valid == 1'b0, "R1 idle after reset", 32'(out_valid), 0);
    endtask

    task automatic t_priority();
        clear_all();
        req_vld = '1;
        for (int k = 0; k < NS; k++) begin
            step(NS'(1) << k, "R7 priority order");
            req_vld[k] = 1'b0;
        end
        step('0, "R8 no request no ack");
    endtask

    task automatic t_mshr_rule();
        clear_all();
        req_vld[6] = 1'b1; mshr_hit[6] = 1'b1; mshr_ent_valid[6] = 1'b1;
        mshr_ent_tag[6] = 8'hEE;
        step('0, "R2 tag mismatch blocks load");
        mshr_ent_tag[6] = req_tag[6]; stall[6] = 1'b1;
        step('0, "R2 stalled match blocks load");
        stall[6] = 1'b0;
        step(8'h40, "R2 clean match issues load");
        mshr_ent_valid[6] = 1'b0; stall[6] = 1'b1; mshr_ent_tag[6] = 8'hEE;
        step(8'h40, "R2 invalid entry issues load");
        mshr_hit[6] = 1'b0; mshr_ent_valid[6] = 1'b1;
        step(8'h40, "R2 no hit issues load");
        clear_all();
        req_vld[5] = 1'b1; mshr_hit[5] = 1'b1; mshr_ent_valid[5] = 1'b1;
        stall[5] = 1'b1;
        step('0, "R2 stalled forwarded blocked");
    endtask

    task automatic t_evict_bypass();
        clear_all();
        req_vld[2] = 1'b1; mshr_hit[2] = 1'b1; mshr_ent_valid[2] = 1'b1;
        stall[2] = 1'b1; mshr_ent_tag[2] = 8'hEE;
        step('0, "R5 stalled replacement without wfe");
        mshr_ent_wfe[2] = 1'b1;
        step(8'h04, "R5 wfe bypasses stall");
        mshr_ent_wfe[2] = 1'b0; stall[2] = 1'b0;
        step(8'h04, "R5 no tag compare on replacement");
    endtask

    task automatic t_ignored();
        clear_all();
        req_vld = 8'b1001_0001;
        mshr_hit = '1; mshr_ent_valid = '1; stall = '1;
        for (int i = 0; i < NS; i++) mshr_ent_tag[i] = 8'hEE;
        step(8'h01, "R4 flush ignores mshr and stall");
        req_vld[0] = 1'b0;
        step(8'h10, "R4 response ignores mshr and stall");
        req_vld[4] = 1'b0;
        step(8'h80, "R4 recycled ignores mshr and stall");
    endtask

    task automatic t_set_clash();
        clear_all();
        req_vld[6] = 1'b1; req_vld[7] = 1'b1;
        s2_busy = 1'b1; s2_set = req_set[6];
        step(8'h80, "R3 stage2 clash skips load");
        s2_busy = 1'b0; s3_busy = 1'b1; s3_set = req_set[7];
        step(8'h40, "R3 stage3 clash no effect on other set");
        req_vld[6] = 1'b0;
        step('0, "R3 stage3 clash blocks recycled");
        s3_set = req_set[6];
        s2_set = req_set[7];
        step(8'h80, "R3 idle stage2 set ignored");
    endtask

    task automatic t_network();
        clear_all();
        req_vld = '1; net_ready = 1'b0;
        step(8'h10, "R6 no network picks response");
        req_vld[4] = 1'b0;
        step(8'h20, "R6 forwarded without network");
        req_vld[5] = 1'b0;
        step(8'h80, "R6 core classes blocked without network");
        req_vld[7] = 1'b0;
        step('0, "R6 nothing left");
    endtask

    task automatic t_payload();
        clear_all();
        req_vld[3] = 1'b1; req_tag[3] = 8'hA5; req_set[3] = 4'h9;
        mshr_hit[3] = 1'b1; mshr_idx[3] = 3'd5; mshr_ent_valid[3] = 1'b0;
        mshr_ent_tag[3] = 8'h3C; mshr_ent_wfe[3] = 1'b1;
        step(8'h08, "R9 store launch");
        chk(out_tag == 8'hA5, "R9 tag", 32'(out_tag), 32'hA5);
        chk(out_set == 4'h9, "R9 set", 32'(out_set), 32'h9);
        chk(out_mshr_hit == 1'b1, "R9 mshr hit", 32'(out_mshr_hit), 1);
        chk(out_mshr_idx == 3'd5, "R9 mshr idx", 32'(out_mshr_idx), 5);
        chk(out_ent_valid == 1'b0, "R9 entry valid", 32'(out_ent_valid), 0);
        chk(out_ent_tag == 8'h3C, "R9 entry tag", 32'(out_ent_tag), 32'h3C);
        chk(out_ent_wfe == 1'b1, "R9 entry wfe", 32'(out_ent_wfe), 1);
        req_vld = '0;
        step('0, "R9 bubble clears valid");
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_priority();
        t_mshr_rule();
        t_evict_bypass();
        t_ignored();
        t_set_clash();
        t_network();
        t_payload();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule